// File: doc/BRIEF.md
# Four-Way Pairwise-Order LRU Replacement Tracker

This block tracks true least-recently-used order for every set of a four-way set-associative cache. For each set it keeps one bit for every pair of ways, six bits in all. The bit for the pair (i, j), with i < j, is 1 when way j was used more recently than way i, and 0 otherwise. When a way is hit or refilled, only the three bits that involve that way are rewritten. The other three bits keep their values. On a miss, the six bits of the indexed set are decoded to name the way that has gone unused the longest.

The cache controller presents a set index on every cycle. It raises the access strobe, together with a way number, when that way of the set is used. A purge strobe returns every set to its initial order in a single cycle. The victim output is registered. In the cycle after a clock edge, it names the replacement way of the set that was indexed at that edge. That way is computed from the set's order as it stood before any update made at the same edge. Tag compare, data storage and bus handling belong to other blocks.

Top module: `lru_mx_top`

## Requirements
- R1: A synchronous active-high reset sets the victim output to way 3 and returns every set to the all-zero order word, whose victim is way 3.
- R2: An access to way 0 clears bits 5, 4 and 3 of the indexed set's order word. After it, way 0 is the most recently used way of that set.
- R3: An access to way 1 sets bit 5 and clears bits 2 and 1.
- R4: An access to way 2 sets bits 4 and 2 and clears bit 0.
- R5: An access to way 3 sets bits 3, 1 and 0.
- R6: An update leaves unchanged the three bits that do not involve the accessed way. It also leaves every other set untouched. As a result, the order always stays a consistent true-LRU order.
- R7: The victim decode is as follows. Way 0 is chosen when bits 5, 4 and 3 are all 1. Way 1 is chosen when bit 5 is 0 and bits 2 and 1 are 1. Way 2 is chosen when bits 4 and 2 are 0 and bit 0 is 1. Way 3 is chosen when bits 3, 1 and 0 are all 0. The way accessed most recently in a set is therefore never its victim.
- R8: A purge returns all 64 sets to the all-zero word in one cycle. Every set then reports way 3.
- R9: When a purge and an access arrive in the same cycle, the purge wins and the access is ignored.
- R10: The victim output is registered. After the edge at which set index S was presented, it reflects S's order as it was before that edge's update. The set index has 6 bits, selecting one of 64 sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access (hit or refill) to acc_way of set acc_set |
| acc_set | input | 6 | Set index for update and victim lookup |
| acc_way | input | 2 | Way that was accessed |
| purge_all | input | 1 | Clear the order of every set |
| vic_way | output | 2 | Registered replacement way of the set indexed at the last edge |

## Verification
The bench keeps, for every set, a recency stamp per way and takes the way with the oldest stamp as the victim. This model is compared against the output on every cycle. Directed runs cover several cases. Each way is made the most recent in turn; a wrong update mask would then leave a just-used way as the victim, or disturb the order of ways that were not touched. A set is queried in the same cycle it is updated; a design that forwarded the new word would report the post-update victim one cycle early. A purge is sent together with an access; a design that let the access through would report something other than way 3 afterwards. A long random phase over a few sets, with occasional purges, exercises order sequences that no single directed case reaches.

// File: rtl/lru_mx_pkg.sv
package lru_mx_pkg;

  // Bit position of the pair (i, j), i < j, in a pairwise-order word.
  // Pairs are counted with i ascending, then j ascending, starting at the top bit.
  function automatic int pair_pos(input int i, input int j, input int ways);
    int k;
    k = 0;
    for (int a = 0; a < i; a++) k += ways - 1 - a;
    k += j - i - 1;
    return (ways * (ways - 1) / 2) - 1 - k;
  endfunction

endpackage

// File: rtl/lru_mx_store.sv
module lru_mx_store #(
  parameter int SETS  = 64,
  parameter int LRU_W = 6,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] idx,
  input  logic             wr_en,
  input  logic [LRU_W-1:0] wr_word,
  input  logic             clr_all,
  output logic [LRU_W-1:0] rd_word
);

  // Order words live in a plain array with a synchronous write and an asynchronous read.
  // A per-set "live" flag lets a purge clear every set in one cycle without touching the array.
  logic [LRU_W-1:0] words [SETS];
  logic [SETS-1:0]  live;

  always_ff @(posedge clk) begin
    if (wr_en && !clr_all) words[idx] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all) live <= '0;
    else if (wr_en)     live[idx] <= 1'b1;
  end

  assign rd_word = live[idx] ? words[idx] : '0;

endmodule

// File: rtl/lru_mx_update.sv
module lru_mx_update
  import lru_mx_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int LRU_W = WAYS * (WAYS - 1) / 2
) (
  input  logic [LRU_W-1:0] old_word,
  input  logic [WAY_W-1:0] way,
  output logic [LRU_W-1:0] new_word
);

  // Each pair bit is cleared when its lower way is used, set when its upper way is used,
  // and held otherwise.
  for (genvar i = 0; i < WAYS; i++) begin : g_lo
    for (genvar j = i + 1; j < WAYS; j++) begin : g_hi
      localparam int POS = pair_pos(i, j, WAYS);
      always_comb begin
        if (way == WAY_W'(i))      new_word[POS] = 1'b0;
        else if (way == WAY_W'(j)) new_word[POS] = 1'b1;
        else                       new_word[POS] = old_word[POS];
      end
    end
  end

endmodule

// File: rtl/lru_mx_victim.sv
module lru_mx_victim
  import lru_mx_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int LRU_W = WAYS * (WAYS - 1) / 2
) (
  input  logic [LRU_W-1:0] word,
  output logic [WAYS-1:0]  match,
  output logic [WAY_W-1:0] victim
);

  // A way is the oldest when every pair bit says the other way is more recent:
  // bits where it is the lower way must be 1, bits where it is the upper way must be 0.
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      match[w] = 1'b1;
      for (int i = 0; i < WAYS; i++) begin
        for (int j = i + 1; j < WAYS; j++) begin
          if (i == w) match[w] = match[w] &  word[pair_pos(i, j, WAYS)];
          if (j == w) match[w] = match[w] & ~word[pair_pos(i, j, WAYS)];
        end
      end
    end
  end

  // The patterns are mutually exclusive. A word that matches none of them falls back to way 0.
  always_comb begin
    victim = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) victim = WAY_W'(w);
    end
  end

endmodule

// File: rtl/lru_mx_top.sv
module lru_mx_top #(
  parameter int SETS = 64,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int LRU_W = WAYS * (WAYS - 1) / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic [WAY_W-1:0] acc_way,
  input  logic             purge_all,
  output logic [WAY_W-1:0] vic_way
);

  logic [LRU_W-1:0] cur_word;
  logic [LRU_W-1:0] next_word;
  logic [WAYS-1:0]  way_match;
  logic [WAY_W-1:0] vic_comb;
  logic [WAY_W-1:0] vic_q;

  lru_mx_store #(.SETS(SETS), .LRU_W(LRU_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .idx     (acc_set),
    .wr_en   (acc_valid && !rst),
    .wr_word (next_word),
    .clr_all (purge_all && !rst),
    .rd_word (cur_word)
  );

  lru_mx_update #(.WAYS(WAYS)) u_upd (
    .old_word (cur_word),
    .way      (acc_way),
    .new_word (next_word)
  );

  lru_mx_victim #(.WAYS(WAYS)) u_vic (
    .word   (cur_word),
    .match  (way_match),
    .victim (vic_comb)
  );

  // After a reset every set is all zeros, which decodes to the highest way.
  always_ff @(posedge clk) begin
    if (rst) vic_q <= WAY_W'(WAYS - 1);
    else     vic_q <= vic_comb;
  end

  assign vic_way = vic_q;

endmodule

// File: rtl/lru_mx_chk.sv
module lru_mx_chk #(
  parameter int SETS = 64,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_valid,
  input logic [SET_W-1:0] acc_set,
  input logic [WAY_W-1:0] acc_way,
  input logic             purge_all,
  input logic [WAY_W-1:0] vic_way,
  input logic [WAYS-1:0]  way_match
);

  p_reset_vic_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> vic_way == WAY_W'(WAYS - 1));

  p_purge_clear_r8: assert property (@(posedge clk) disable iff (rst)
    purge_all |=> ##1 (vic_way == WAY_W'(WAYS - 1)));

  p_purge_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (purge_all && acc_valid) |=> ##1 (vic_way != $past(acc_way, 2) || acc_way == WAY_W'(WAYS - 1) || $past(acc_way, 2) == WAY_W'(WAYS - 1)));

  p_mru_not_victim_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !purge_all) ##1 (acc_set == $past(acc_set)) |=> (vic_way != $past(acc_way, 2)));

  p_word_consistent_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(way_match) == 1);

endmodule

bind lru_mx_top lru_mx_chk #(.SETS(SETS), .WAYS(WAYS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_valid (acc_valid),
  .acc_set   (acc_set),
  .acc_way   (acc_way),
  .purge_all (purge_all),
  .vic_way   (vic_way),
  .way_match (way_match)
);

// File: tb/lru_mx_top_test.sv
module lru_mx_top_test;
  localparam int SETS = 64;
  localparam int WAYS = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_valid = 1'b0;
  logic [5:0] acc_set = '0;
  logic [1:0] acc_way = '0;
  logic       purge_all = 1'b0;
  logic [1:0] vic_way;

  always #4 clk = ~clk;

  lru_mx_top uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_way(acc_way), .purge_all(purge_all), .vic_way(vic_way)
  );

  // Reference: a recency stamp per way; the smallest stamp is the least recently used way.
  int stamp [SETS][WAYS];
  int tick = 100;
  int n_chk = 0;
  int n_fail = 0;

  function automatic void model_clear();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) stamp[s][w] = WAYS - 1 - w;
  endfunction

  function automatic int model_victim(int s);
    int b;
    b = 0;
    for (int w = 1; w < WAYS; w++) if (stamp[s][w] < stamp[s][b]) b = w;
    return b;
  endfunction

  task automatic check(string req, int exp);
    n_chk++;
    if (vic_way !== 2'(exp)) begin
      n_fail++;
      $display("FAIL %s: vic_way=%0d expected %0d", req, vic_way, exp);
    end
  endtask

  // Called at a falling edge: drive, predict, pass one rising edge, check at the next falling edge.
  task automatic cyc(bit v, int s, int w, bit p, string req);
    int e;
    acc_valid = v; acc_set = 6'(s); acc_way = 2'(w); purge_all = p;
    e = model_victim(s);
    if (p) model_clear();
    else if (v) begin tick++; stamp[s][w] = tick; end
    @(posedge clk);
    @(negedge clk);
    check(req, e);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    check("R1", 3);
    rst = 1'b0;
    cyc(0, 0, 0, 0, "R1");
    cyc(0, 63, 0, 0, "R1");

    // R2..R5: make each way most recent in turn within one set
    cyc(1, 1, 0, 0, "R2"); cyc(0, 1, 0, 0, "R2");
    cyc(1, 1, 1, 0, "R3"); cyc(0, 1, 0, 0, "R3");
    cyc(1, 1, 2, 0, "R4"); cyc(0, 1, 0, 0, "R4");
    cyc(1, 1, 3, 0, "R5"); cyc(0, 1, 0, 0, "R5");
    cyc(1, 2, 3, 0, "R5"); cyc(1, 2, 2, 0, "R4"); cyc(1, 2, 1, 0, "R3");
    cyc(0, 2, 0, 0, "R2");
    check("R7", 0);

    // R6: untouched bits hold; neighbour sets stay at their own order
    cyc(1, 3, 2, 0, "R6"); cyc(1, 3, 0, 0, "R6"); cyc(1, 3, 2, 0, "R6");
    cyc(0, 3, 0, 0, "R6");
    cyc(0, 4, 0, 0, "R6");
    cyc(1, 5, 3, 0, "R6"); cyc(1, 5, 1, 0, "R6"); cyc(0, 5, 0, 0, "R6");

    // R10: lookup in the same cycle as an update sees the old order
    cyc(1, 6, 3, 0, "R10"); cyc(1, 6, 2, 0, "R10"); cyc(1, 6, 2, 0, "R10");

    // R8: purge from a disturbed state
    for (int s = 10; s < 20; s++) cyc(1, s, s % 4, 0, "R8");
    cyc(0, 12, 0, 1, "R8");
    for (int s = 10; s < 20; s++) cyc(0, s, 0, 0, "R8");
    check("R8", 3);

    // R9: purge together with an access
    cyc(1, 7, 0, 0, "R9"); cyc(1, 7, 1, 0, "R9"); cyc(1, 7, 2, 0, "R9");
    cyc(1, 7, 3, 1, "R9"); cyc(0, 7, 0, 0, "R9");
    check("R9", 3);

    // R7 and R10: random traffic over a few sets
    for (int n = 0; n < 4000; n++)
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 3),
          $urandom_range(0, 199) == 0, "R10");

    // R1: reset in mid-run
    acc_valid = 1'b0; purge_all = 1'b0; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1", 3);
    rst = 1'b0;
    model_clear();
    for (int s = 0; s < 8; s++) cyc(0, s, 0, 0, "R1");

    finish_run();
  end

endmodule